// File: doc/BRIEF.md
# LCD Controller Register File

This block is the software-visible register front end of a display controller. A simple 32-bit bus accesses it with a select, a write flag and a 12-bit byte offset. It holds four timing words, two frame base addresses, a control word, an interrupt mask and a raw interrupt status with a write-one-to-clear port. Read-only identification bytes sit at the top of the window. A 128-word palette range is not stored here: accesses to it are forwarded to external palette storage, and the read data is taken from that storage in the response cycle.

From the stored words the block derives the active width and height, the pixel depth code and a display enable for the scan-out engine. It also raises a one-cycle restart pulse when geometry or control changes, and drives an interrupt line from the masked status. The `VARIANT` parameter selects one of three builds. Variant 0 is the base layout. Variant 1 exchanges the mask and control offsets. Variant 2 exchanges them as well and also reports a different identification prefix.

Top module: `lcd_reg_file`

## Requirements
- R1: Word offsets 0 to 3 (byte 0x000 to 0x00C) store timing words 0 to 3. Offset 4 (0x010) stores the upper frame base and offset 5 (0x014) the lower frame base. Each reads back the last written 32-bit value, and all of them reset to zero.
- R2: With `VARIANT`=0, byte 0x018 is the interrupt mask and 0x01C is the control word. With `VARIANT` 1 or 2, the two are exchanged for reads and writes alike. The mask keeps only its low `IRQ_W` bits and reads back zero-extended.
- R3: A read of 0x020 returns the raw interrupt status. A read of 0x024 returns the raw status ANDed with the mask.
- R4: A write to 0x028 clears every status bit whose data bit is 1. Bits of the `irqSet` input set status bits on the same edge, and a set wins over a clear in the same cycle.
- R5: Reads of 0x02C and 0x030 return the upper and lower frame base respectively.
- R6: `widthPx` equals ((timing0 AND 0xFC) + 4) * 4. It is 16 after reset and 1024 at most.
- R7: `heightPx` equals timing1[9:0] + 1. It is 1 after reset.
- R8: `depthMode` is control[3:1] and `ctrlWord` is the whole control word. `dispEnable` is 1 only when control bit 0 and control bit 11 are both 1.
- R9: Reads of bytes 0xFE0 to 0xFFC return one identification byte per word, zero-extended: 10 11 04 00 0D F0 05 B1 in address order. With `VARIANT`=2 the first four are 11 11 24 00.
- R10: An access to bytes 0x200 to 0x3FF asserts `palSel` in the same cycle, together with `palWrite` for a write. It presents `palIndex` = byte offset[8:2] and `palWdata` = write data. For a read, `rdData` in the response cycle equals `palRdata`.
- R11: Reads of unmapped or non-word-aligned offsets return 0, and so do reads of 0x028. Writes to unmapped offsets change no register, output or pulse.
- R12: `restartPulse` is high for exactly the cycle after each write to a timing word or the control word. Writes to bases, mask or clear do not raise it.
- R13: `irqOut` is the OR of the masked status bits. It follows the status registers combinationally.
- R14: `rdValid` is high for exactly the cycle after a read access and is low after a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busSel | input | 1 | Access strobe, one cycle per access |
| busWrite | input | 1 | 1 = write, 0 = read |
| busAddr | input | 12 | Byte offset |
| busWdata | input | DATA_W | Write data |
| rdData | output | DATA_W | Read data, valid while rdValid |
| rdValid | output | 1 | Read response cycle |
| palSel | output | 1 | Palette window access |
| palWrite | output | 1 | Palette window write |
| palIndex | output | 7 | Palette word index |
| palWdata | output | DATA_W | Palette write data |
| palRdata | input | DATA_W | Palette read data, sampled in the response cycle |
| irqSet | input | IRQ_W | Status set pulses from interrupt sources |
| irqOut | output | 1 | OR of masked status |
| dispEnable | output | 1 | Enable and power both set |
| depthMode | output | 3 | Pixel depth code |
| ctrlWord | output | DATA_W | Full control word |
| widthPx | output | 11 | Active width in pixels |
| heightPx | output | 11 | Active height in lines |
| restartPulse | output | 1 | Geometry or control changed |

## Verification
The bench builds two copies side by side on one shared bus: `VARIANT`=0 as `dut_i` and `VARIANT`=2 as a second instance. Every single write then lands on the mask in one copy and on the control word in the other. The exchanged offsets, the restart pulse appearing on only one copy, the different masked-interrupt results and the two identification prefixes are therefore all compared within the same stimulus. `VARIANT`=1 differs from 2 only in the identification prefix, so it adds nothing beyond what these two builds reach.

// File: rtl/lcd_regs_pkg.sv
package lcd_regs_pkg;

  localparam int ADDR_W    = 12;
  localparam int PAL_IDX_W = 7;
  localparam int PIX_W     = 11;
  localparam int LINE_FW   = 10;
  localparam int NUM_TIM   = 4;
  localparam int EN_BIT    = 0;
  localparam int PWR_BIT   = 11;

  typedef enum logic [3:0] {
    SEL_ZERO, SEL_TIM0, SEL_TIM1, SEL_TIM2, SEL_TIM3,
    SEL_UPB, SEL_LPB, SEL_MASK, SEL_CTRL,
    SEL_RAW, SEL_MSKD, SEL_ID, SEL_PAL
  } rdSel_e;

  typedef struct packed {
    logic [NUM_TIM-1:0] wrTiming;
    logic               wrUpBase;
    logic               wrLpBase;
    logic               wrMask;
    logic               wrCtrl;
    logic               wrClear;
    logic               rdStrobe;
    rdSel_e             rdSel;
    logic [2:0]         idIdx;
  } regStrobe_t;

  function automatic logic [7:0] idByte(input logic extId, input logic [2:0] idx);
    case (idx)
      3'd0:    idByte = extId ? 8'h11 : 8'h10;
      3'd1:    idByte = 8'h11;
      3'd2:    idByte = extId ? 8'h24 : 8'h04;
      3'd3:    idByte = 8'h00;
      3'd4:    idByte = 8'h0D;
      3'd5:    idByte = 8'hF0;
      3'd6:    idByte = 8'h05;
      default: idByte = 8'hB1;
    endcase
  endfunction

endpackage

// File: rtl/lcd_reg_decode.sv
module lcd_reg_decode
  import lcd_regs_pkg::*;
#(
  parameter bit IS_SWAPPED = 1'b0
) (
  input  logic                 busSel,
  input  logic                 busWrite,
  input  logic [ADDR_W-1:0]    busAddr,
  output regStrobe_t           strb,
  output logic                 palSel,
  output logic                 palWrite,
  output logic [PAL_IDX_W-1:0] palIndex
);

  localparam logic [3:0] MASK_OFF = IS_SWAPPED ? 4'd7 : 4'd6;

  logic aligned, inLow, inPal, inId, wrAcc, rdAcc;
  logic [3:0] lowIdx;

  assign aligned = (busAddr[1:0] == 2'b00);
  assign inLow   = aligned && (busAddr[11:6] == 6'd0);
  assign inPal   = aligned && (busAddr[11:9] == 3'b001);
  assign inId    = aligned && (busAddr[11:5] == 7'h7F);
  assign lowIdx  = busAddr[5:2];
  assign wrAcc   = busSel && busWrite;
  assign rdAcc   = busSel && !busWrite;

  always_comb begin
    strb          = '0;
    strb.rdSel    = SEL_ZERO;
    strb.rdStrobe = rdAcc;
    strb.idIdx    = busAddr[4:2];
    if (inLow) begin
      case (lowIdx)
        4'd0: begin strb.wrTiming[0] = wrAcc; strb.rdSel = SEL_TIM0; end
        4'd1: begin strb.wrTiming[1] = wrAcc; strb.rdSel = SEL_TIM1; end
        4'd2: begin strb.wrTiming[2] = wrAcc; strb.rdSel = SEL_TIM2; end
        4'd3: begin strb.wrTiming[3] = wrAcc; strb.rdSel = SEL_TIM3; end
        4'd4: begin strb.wrUpBase = wrAcc; strb.rdSel = SEL_UPB; end
        4'd5: begin strb.wrLpBase = wrAcc; strb.rdSel = SEL_LPB; end
        4'd6, 4'd7: begin
          if (lowIdx == MASK_OFF) begin
            strb.wrMask = wrAcc;
            strb.rdSel  = SEL_MASK;
          end else begin
            strb.wrCtrl = wrAcc;
            strb.rdSel  = SEL_CTRL;
          end
        end
        4'd8:  strb.rdSel = SEL_RAW;
        4'd9:  strb.rdSel = SEL_MSKD;
        4'd10: strb.wrClear = wrAcc;
        4'd11: strb.rdSel = SEL_UPB;
        4'd12: strb.rdSel = SEL_LPB;
        default: strb.rdSel = SEL_ZERO;
      endcase
    end else if (inPal) begin
      strb.rdSel = SEL_PAL;
    end else if (inId) begin
      strb.rdSel = SEL_ID;
    end
  end

  assign palSel   = busSel && inPal;
  assign palWrite = wrAcc && inPal;
  assign palIndex = busAddr[8:2];

endmodule

// File: rtl/lcd_reg_store.sv
module lcd_reg_store
  import lcd_regs_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int IRQ_W  = 5,
  parameter bit EXT_ID = 1'b0
) (
  input  logic              clk,
  input  logic              rstN,
  input  regStrobe_t        strb,
  input  logic [DATA_W-1:0] busWdata,
  input  logic [IRQ_W-1:0]  irqSet,
  input  logic [DATA_W-1:0] palRdata,
  output logic [DATA_W-1:0] rdData,
  output logic              rdValid,
  output logic [DATA_W-1:0] timing0,
  output logic [DATA_W-1:0] timing1,
  output logic [DATA_W-1:0] ctrlReg,
  output logic              irqOut,
  output logic              restartPulse
);

  logic [DATA_W-1:0] timReg [NUM_TIM];
  logic [DATA_W-1:0] upBase, lpBase, rdReg, rdMux;
  logic [IRQ_W-1:0]  maskReg, rawStat, clrBits;
  logic              rdPalQ, rdValidQ, restartQ;

  for (genvar t = 0; t < NUM_TIM; t++) begin : g_tim
    always_ff @(posedge clk) begin
      if (!rstN)                timReg[t] <= '0;
      else if (strb.wrTiming[t]) timReg[t] <= busWdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      upBase  <= '0;
      lpBase  <= '0;
      ctrlReg <= '0;
      maskReg <= '0;
    end else begin
      if (strb.wrUpBase) upBase  <= busWdata;
      if (strb.wrLpBase) lpBase  <= busWdata;
      if (strb.wrCtrl)   ctrlReg <= busWdata;
      if (strb.wrMask)   maskReg <= busWdata[IRQ_W-1:0];
    end
  end

  assign clrBits = strb.wrClear ? busWdata[IRQ_W-1:0] : '0;

  always_ff @(posedge clk) begin
    if (!rstN) rawStat <= '0;
    else       rawStat <= (rawStat & ~clrBits) | irqSet;
  end

  always_comb begin
    rdMux = '0;
    case (strb.rdSel)
      SEL_TIM0: rdMux = timReg[0];
      SEL_TIM1: rdMux = timReg[1];
      SEL_TIM2: rdMux = timReg[2];
      SEL_TIM3: rdMux = timReg[3];
      SEL_UPB:  rdMux = upBase;
      SEL_LPB:  rdMux = lpBase;
      SEL_MASK: rdMux[IRQ_W-1:0] = maskReg;
      SEL_CTRL: rdMux = ctrlReg;
      SEL_RAW:  rdMux[IRQ_W-1:0] = rawStat;
      SEL_MSKD: rdMux[IRQ_W-1:0] = rawStat & maskReg;
      SEL_ID:   rdMux[7:0] = idByte(EXT_ID, strb.idIdx);
      default:  rdMux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdReg    <= '0;
      rdPalQ   <= 1'b0;
      rdValidQ <= 1'b0;
      restartQ <= 1'b0;
    end else begin
      rdValidQ <= strb.rdStrobe;
      rdPalQ   <= strb.rdStrobe && (strb.rdSel == SEL_PAL);
      if (strb.rdStrobe) rdReg <= rdMux;
      restartQ <= (|strb.wrTiming) || strb.wrCtrl;
    end
  end

  assign rdData       = rdPalQ ? palRdata : rdReg;
  assign rdValid      = rdValidQ;
  assign restartPulse = restartQ;
  assign irqOut       = |(rawStat & maskReg);
  assign timing0      = timReg[0];
  assign timing1      = timReg[1];

endmodule

// File: rtl/lcd_geom_decode.sv
module lcd_geom_decode
  import lcd_regs_pkg::*;
(
  input  logic [5:0]         ppl,
  input  logic [LINE_FW-1:0] lpp,
  input  logic               enBit,
  input  logic               pwrBit,
  input  logic [2:0]         depthBits,
  output logic [PIX_W-1:0]   widthPx,
  output logic [PIX_W-1:0]   heightPx,
  output logic [2:0]         depthMode,
  output logic               dispEnable
);

  logic [PIX_W-1:0] pplSum;

  assign pplSum     = {{(PIX_W-8){1'b0}}, ppl, 2'b00} + PIX_W'(4);
  assign widthPx    = {pplSum[PIX_W-3:0], 2'b00};
  assign heightPx   = {{(PIX_W-LINE_FW){1'b0}}, lpp} + PIX_W'(1);
  assign depthMode  = depthBits;
  assign dispEnable = enBit && pwrBit;

endmodule

// File: rtl/lcd_reg_file.sv
module lcd_reg_file
  import lcd_regs_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int IRQ_W   = 5,
  parameter int VARIANT = 0
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 busSel,
  input  logic                 busWrite,
  input  logic [ADDR_W-1:0]    busAddr,
  input  logic [DATA_W-1:0]    busWdata,
  output logic [DATA_W-1:0]    rdData,
  output logic                 rdValid,
  output logic                 palSel,
  output logic                 palWrite,
  output logic [PAL_IDX_W-1:0] palIndex,
  output logic [DATA_W-1:0]    palWdata,
  input  logic [DATA_W-1:0]    palRdata,
  input  logic [IRQ_W-1:0]     irqSet,
  output logic                 irqOut,
  output logic                 dispEnable,
  output logic [2:0]           depthMode,
  output logic [DATA_W-1:0]    ctrlWord,
  output logic [PIX_W-1:0]     widthPx,
  output logic [PIX_W-1:0]     heightPx,
  output logic                 restartPulse
);

  localparam bit IS_SWAPPED = (VARIANT != 0);
  localparam bit EXT_ID     = (VARIANT == 2);

  regStrobe_t        strb;
  logic [DATA_W-1:0] timing0, timing1, ctrlReg;

  lcd_reg_decode #(.IS_SWAPPED(IS_SWAPPED)) decode_i (
    .busSel(busSel), .busWrite(busWrite), .busAddr(busAddr),
    .strb(strb), .palSel(palSel), .palWrite(palWrite), .palIndex(palIndex)
  );

  lcd_reg_store #(.DATA_W(DATA_W), .IRQ_W(IRQ_W), .EXT_ID(EXT_ID)) store_i (
    .clk(clk), .rstN(rstN), .strb(strb), .busWdata(busWdata),
    .irqSet(irqSet), .palRdata(palRdata), .rdData(rdData), .rdValid(rdValid),
    .timing0(timing0), .timing1(timing1), .ctrlReg(ctrlReg),
    .irqOut(irqOut), .restartPulse(restartPulse)
  );

  lcd_geom_decode geom_i (
    .ppl(timing0[7:2]), .lpp(timing1[LINE_FW-1:0]),
    .enBit(ctrlReg[EN_BIT]), .pwrBit(ctrlReg[PWR_BIT]), .depthBits(ctrlReg[3:1]),
    .widthPx(widthPx), .heightPx(heightPx), .depthMode(depthMode),
    .dispEnable(dispEnable)
  );

  assign palWdata = busWdata;
  assign ctrlWord = ctrlReg;

endmodule

// File: rtl/lcd_reg_file_chk.sv
module lcd_reg_file_chk #(
  parameter int DATA_W = 32,
  parameter int IRQ_W  = 5
) (
  input logic              clk,
  input logic              rstN,
  input logic              busSel,
  input logic              busWrite,
  input logic [11:0]       busAddr,
  input logic [DATA_W-1:0] busWdata,
  input logic [DATA_W-1:0] rdData,
  input logic              rdValid,
  input logic              palSel,
  input logic [6:0]        palIndex,
  input logic [IRQ_W-1:0]  irqSet,
  input logic              irqOut,
  input logic              dispEnable,
  input logic [DATA_W-1:0] ctrlWord,
  input logic [10:0]       heightPx,
  input logic              restartPulse
);

  AST_READ_RESPONDS: assert property (@(posedge clk) disable iff (!rstN)
    busSel && !busWrite |=> rdValid); // R14

  AST_WRITE_NO_RESPONSE: assert property (@(posedge clk) disable iff (!rstN)
    busSel && busWrite |=> !rdValid); // R14

  AST_UNMAPPED_READ_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    busSel && !busWrite && busAddr >= 12'h400 && busAddr < 12'hFE0 |=> rdData == '0); // R11

  AST_CLEAR_ALL_QUIETS: assert property (@(posedge clk) disable iff (!rstN)
    busSel && busWrite && busAddr == 12'h028 && (&busWdata[IRQ_W-1:0]) && irqSet == '0
    |=> !irqOut); // R4

  AST_NO_POWER_NO_ENABLE: assert property (@(posedge clk) disable iff (!rstN)
    !ctrlWord[11] |-> !dispEnable); // R8

  AST_PALETTE_FORWARD: assert property (@(posedge clk) disable iff (!rstN)
    busSel && busAddr[11:9] == 3'b001 && busAddr[1:0] == 2'b00
    |-> palSel && palIndex == busAddr[8:2]); // R10

  AST_RESTART_NEEDS_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    restartPulse |-> $past(busSel && busWrite)); // R12

  AST_HEIGHT_NONZERO: assert property (@(posedge clk) disable iff (!rstN)
    heightPx != '0); // R7

endmodule

bind lcd_reg_file lcd_reg_file_chk #(.DATA_W(DATA_W), .IRQ_W(IRQ_W)) chk_i (
  .clk(clk), .rstN(rstN), .busSel(busSel), .busWrite(busWrite), .busAddr(busAddr),
  .busWdata(busWdata), .rdData(rdData), .rdValid(rdValid), .palSel(palSel),
  .palIndex(palIndex), .irqSet(irqSet), .irqOut(irqOut), .dispEnable(dispEnable),
  .ctrlWord(ctrlWord), .heightPx(heightPx), .restartPulse(restartPulse)
);

// File: tb/lcd_reg_file_tb_top.sv
module lcd_reg_file_tb_top;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #5 clk = ~clk;

  logic        sel = 0, wr = 0;
  logic [11:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [4:0]  irqSet = '0;
  logic [6:0]  palIdxQ = '0;
  logic [31:0] palRd;

  logic [31:0] rdA, rdB, palWdA, palWdB, ctrlA, ctrlB;
  logic        vA, vB, psA, psB, pwA, pwB, irqA, irqB, enA, enB, rsA, rsB;
  logic [6:0]  piA, piB;
  logic [2:0]  dmA, dmB;
  logic [10:0] wA, wB, hA, hB;

  lcd_reg_file #(.VARIANT(0)) dut_i (
    .clk(clk), .rstN(rstN), .busSel(sel), .busWrite(wr), .busAddr(addr), .busWdata(wdata),
    .rdData(rdA), .rdValid(vA), .palSel(psA), .palWrite(pwA), .palIndex(piA),
    .palWdata(palWdA), .palRdata(palRd), .irqSet(irqSet), .irqOut(irqA),
    .dispEnable(enA), .depthMode(dmA), .ctrlWord(ctrlA), .widthPx(wA), .heightPx(hA),
    .restartPulse(rsA));

  lcd_reg_file #(.VARIANT(2)) dut_x (
    .clk(clk), .rstN(rstN), .busSel(sel), .busWrite(wr), .busAddr(addr), .busWdata(wdata),
    .rdData(rdB), .rdValid(vB), .palSel(psB), .palWrite(pwB), .palIndex(piB),
    .palWdata(palWdB), .palRdata(palRd), .irqSet(irqSet), .irqOut(irqB),
    .dispEnable(enB), .depthMode(dmB), .ctrlWord(ctrlB), .widthPx(wB), .heightPx(hB),
    .restartPulse(rsB));

  always @(posedge clk) if (psA) palIdxQ <= piA;
  assign palRd = 32'hA5A5_0000 | {25'd0, palIdxQ};

  int nChecks = 0, nFail = 0;
  logic [31:0] qExpA[$], qExpB[$];
  string       qTagA[$], qTagB[$];
  logic        lastRsA, lastRsB;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Monitor: pops expected read data as responses appear
  always @(negedge clk) begin
    if (vA) begin
      if (qExpA.size() == 0) chk("R14 unexpected response A", 32'd1, 32'd0);
      else chk(qTagA.pop_front(), rdA, qExpA.pop_front());
    end
    if (vB) begin
      if (qExpB.size() == 0) chk("R14 unexpected response B", 32'd1, 32'd0);
      else chk(qTagB.pop_front(), rdB, qExpB.pop_front());
    end
  end

  task automatic busWr(logic [11:0] a, logic [31:0] d);
    @(negedge clk); sel = 1; wr = 1; addr = a; wdata = d;
    @(negedge clk); sel = 0; wr = 0;
    lastRsA = rsA; lastRsB = rsB;
    chk("R14 no response after write", {31'd0, vA | vB}, 32'd0);
  endtask

  task automatic busRd(logic [11:0] a, logic [31:0] expA, logic [31:0] expB, string tag);
    @(negedge clk); sel = 1; wr = 0; addr = a;
    qExpA.push_back(expA); qTagA.push_back({tag, " A"});
    qExpB.push_back(expB); qTagB.push_back({tag, " B"});
    @(negedge clk); sel = 0;
  endtask

  task automatic pulseIrq(logic [4:0] v);
    @(negedge clk); irqSet = v;
    @(negedge clk); irqSet = '0;
  endtask

  logic [7:0] idBase [8] = '{8'h10, 8'h11, 8'h04, 8'h00, 8'h0D, 8'hF0, 8'h05, 8'hB1};
  logic [7:0] idExt  [8] = '{8'h11, 8'h11, 8'h24, 8'h00, 8'h0D, 8'hF0, 8'h05, 8'hB1};

  initial begin
    repeat (50000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog expired");
    $display("  TB_RESULT checks=%0d failures=%0d", nChecks, nFail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    // reset state: R6 R7 R8 R13 R14
    chk("R6 reset width", {21'd0, wA}, 32'd16);
    chk("R7 reset height", {21'd0, hA}, 32'd1);
    chk("R8 reset enable", {31'd0, enA}, 32'd0);
    chk("R13 reset irq", {31'd0, irqA}, 32'd0);
    chk("R14 reset valid", {31'd0, vA}, 32'd0);

    busWr(12'h000, 32'hFF);
    chk("R12 restart on timing0", {31'd0, lastRsA}, 32'd1);
    chk("R6 width max", {21'd0, wA}, 32'd1024);
    busWr(12'h000, 32'h13);
    chk("R6 width 80 A", {21'd0, wA}, 32'd80);
    chk("R6 width 80 B", {21'd0, wB}, 32'd80);
    busWr(12'h004, 32'hC1F);
    chk("R7 height 32", {21'd0, hA}, 32'd32);
    busWr(12'h008, 32'h1234_5678);
    busWr(12'h00C, 32'h9ABC_DEF0);
    busRd(12'h000, 32'h13, 32'h13, "R1 timing0");
    busRd(12'h004, 32'hC1F, 32'hC1F, "R1 timing1");
    busRd(12'h008, 32'h1234_5678, 32'h1234_5678, "R1 timing2");
    busRd(12'h00C, 32'h9ABC_DEF0, 32'h9ABC_DEF0, "R1 timing3");

    busWr(12'h010, 32'h1000_0000);
    chk("R12 no restart on base write", {31'd0, lastRsA}, 32'd0);
    busWr(12'h014, 32'h2000_0400);
    busRd(12'h010, 32'h1000_0000, 32'h1000_0000, "R1 upper base");
    busRd(12'h014, 32'h2000_0400, 32'h2000_0400, "R1 lower base");
    busRd(12'h02C, 32'h1000_0000, 32'h1000_0000, "R5 upper current");
    busRd(12'h030, 32'h2000_0400, 32'h2000_0400, "R5 lower current");

    busWr(12'h01C, 32'h809);
    chk("R12 restart control A", {31'd0, lastRsA}, 32'd1);
    chk("R12 no restart mask B", {31'd0, lastRsB}, 32'd0);
    chk("R8 enable A", {31'd0, enA}, 32'd1);
    chk("R8 depth A", {29'd0, dmA}, 32'd4);
    chk("R8 ctrl word A", ctrlA, 32'h809);
    busWr(12'h018, 32'h1F);
    chk("R2 no restart mask A", {31'd0, lastRsA}, 32'd0);
    chk("R2 restart control B", {31'd0, lastRsB}, 32'd1);
    chk("R8 enable needs power B", {31'd0, enB}, 32'd0);
    chk("R8 depth B", {29'd0, dmB}, 32'd7);
    busRd(12'h018, 32'h1F, 32'h1F, "R2 offset 0x18");
    busRd(12'h01C, 32'h809, 32'h09, "R2 offset 0x1C");

    pulseIrq(5'h06);
    chk("R13 irq A", {31'd0, irqA}, 32'd1);
    chk("R13 irq B masked", {31'd0, irqB}, 32'd0);
    busRd(12'h020, 32'h06, 32'h06, "R3 raw");
    busRd(12'h024, 32'h06, 32'h00, "R3 masked");
    busWr(12'h028, 32'h2);
    busRd(12'h020, 32'h04, 32'h04, "R4 partial clear");
    pulseIrq(5'h01);
    chk("R13 irq B after bit0", {31'd0, irqB}, 32'd1);
    busRd(12'h024, 32'h05, 32'h01, "R3 masked after set");
    @(negedge clk); sel = 1; wr = 1; addr = 12'h028; wdata = 32'h08; irqSet = 5'h08;
    @(negedge clk); sel = 0; wr = 0; irqSet = '0;
    busRd(12'h020, 32'h0D, 32'h0D, "R4 set wins over clear");
    busWr(12'h028, 32'hFFFF_FFFF);
    chk("R4 clear all irq A", {31'd0, irqA}, 32'd0);
    busRd(12'h020, 32'h0, 32'h0, "R4 cleared");

    for (int i = 0; i < 8; i++)
      busRd(12'hFE0 + 12'(4*i), {24'd0, idBase[i]}, {24'd0, idExt[i]}, "R9 id byte");

    @(negedge clk); sel = 1; wr = 1; addr = 12'h204; wdata = 32'h0BAD_F00D;
    #1;
    chk("R10 palette write strobe", {30'd0, psA, pwA}, 32'd3);
    chk("R10 palette index", {25'd0, piA}, 32'd1);
    chk("R10 palette wdata", palWdA, 32'h0BAD_F00D);
    @(negedge clk); sel = 0; wr = 0;
    busRd(12'h3FC, 32'hA5A5_007F, 32'hA5A5_007F, "R10 palette read top");
    busRd(12'h200, 32'hA5A5_0000, 32'hA5A5_0000, "R10 palette read bottom");

    busRd(12'h034, 32'h0, 32'h0, "R11 unmapped low");
    busRd(12'h400, 32'h0, 32'h0, "R11 unmapped mid");
    busRd(12'h028, 32'h0, 32'h0, "R11 clear reads zero");
    busRd(12'h002, 32'h0, 32'h0, "R11 unaligned");
    busWr(12'h034, 32'hFFFF_FFFF);
    chk("R11 no restart unmapped", {31'd0, lastRsA}, 32'd0);
    busWr(12'h800, 32'hFFFF_FFFF);
    chk("R11 width kept", {21'd0, wA}, 32'd80);
    busRd(12'h000, 32'h13, 32'h13, "R11 timing kept");

    busWr(12'h01C, 32'h800);
    chk("R8 power only", {31'd0, enA}, 32'd0);
    chk("R8 depth zero", {29'd0, dmA}, 32'd0);

    repeat (4) @(negedge clk);
    chk("R14 queue drained", 32'(qExpA.size() + qExpB.size()), 32'd0);
    $display("  TB_RESULT checks=%0d failures=%0d", nChecks, nFail);
    $finish;
  end

endmodule